// File: doc/BRIEF.md
# Clock Failure Monitor

This block watches a primary clock and moves the system onto an internal clock when the primary clock stops. It runs on a fast system clock. The primary clock, a free-running low-frequency reference clock and a start-up-done indication are brought in through two-flop synchronizers, and their edges are detected in the system clock domain.

The reference clock is divided down to a slow sample clock. A detector latch is set by every falling edge of the primary clock and cleared by every rising edge of the sample clock. If the latch is still clear when the sample clock falls, a whole high half-period has passed with no low-going primary edge, and the monitor declares a failure. On a failure it asserts the internal-clock select, sets a sticky flag and, when the interrupt enable is set, raises an interrupt.

The block never returns to the primary clock on its own. A failure is cleared by reset, by disabling the monitor, or by a toggle strobe from the clock-source select. In crystal mode the toggle starts a re-arm timer that counts primary-clock falling edges. The internal select is held until that count completes. In external-clock or RC mode no timer is used, and the toggle clears the failure at once.

Top module: `clk_fail_monitor`

## Requirements
- R1: While the primary clock keeps running at a rate well above the sample clock, no failure is declared and the internal-clock select stays low.
- R2: When the primary clock stops (is held high with no falling edge), the flag and the internal-clock select both go high within two sample-clock periods plus the synchronizer latency.
- R3: A failure is declared only at a falling edge of the sample clock, after a sample-clock high phase that saw no primary falling edge. The flag therefore stays low for at least one sample half-period after the last primary falling edge.
- R4: The interrupt output is high only when the flag is set and the interrupt enable is high. Clearing the enable drops the interrupt while the flag stays set.
- R5: Once a failure is declared, the internal-clock select stays high even after the primary clock resumes, until a clearing event occurs.
- R6: Pulsing the flag-clear input drops the flag without releasing the internal-clock select.
- R7: With the crystal-mode input low (external clock or RC), a toggle strobe during a failure releases the internal-clock select within a few system cycles.
- R8: With the crystal-mode input high, a toggle strobe during a failure keeps the internal-clock select high until OST_CYCLES primary falling edges have been counted, and then releases it.
- R9: With the crystal-mode input high, no failure is declared while the start-up-done input is low.
- R10: While the monitor enable is low, the flag, the interrupt and the internal-clock select are held low, and a stopped primary clock raises nothing.
- R11: A toggle strobe while no failure is present has no effect on the flag or on the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prim_clk | input | 1 | Primary clock being watched (asynchronous) |
| ref_clk | input | 1 | Low-frequency reference clock (asynchronous) |
| ost_done | input | 1 | Start-up timer expired (asynchronous level) |
| mon_en | input | 1 | Monitor enable |
| osc_crystal | input | 1 | 1 = crystal mode (re-arm timer used), 0 = external clock or RC |
| src_toggle | input | 1 | One-cycle strobe: clock-source select bit was toggled |
| flag_clr | input | 1 | One-cycle strobe: clear the fail flag |
| irq_en | input | 1 | Interrupt enable |
| fail_flag | output | 1 | Sticky failure flag |
| fail_irq | output | 1 | Interrupt request |
| force_internal | output | 1 | Selects the internal clock while high |

## Verification
The bench builds the block with a reference divide of 8 instead of 64 and a re-arm count of 16 primary edges instead of 1024. With those values a detection window is 240 ns and a full re-arm takes well under a microsecond, so each stop, recovery and re-arm sequence fits in a few thousand system cycles. The short settings also make the lower bound on detection latency and the hold time of the select during re-arm measurable, in a run that still allows several scenarios with a fresh reset each.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  typedef enum logic {
    OSC_EXT_OR_RC = 1'b0,
    OSC_CRYSTAL   = 1'b1
  } osc_kind_e;

  localparam int unsigned CFM_SYNC_STAGES = 2;
endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= d_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/cfm_divider.sv
module cfm_divider #(
  parameter int unsigned DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  output logic samp_rise,
  output logic samp_fall
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      samp_rise <= 1'b0;
      samp_fall <= 1'b0;
    end else begin
      samp_rise <= 1'b0;
      samp_fall <= 1'b0;
      if (ref_rise) begin
        if (cnt_q == CW'(DIV - 1)) begin
          cnt_q     <= '0;
          samp_rise <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(HALF - 1)) samp_fall <= 1'b1;
        end
      end
    end
  end

  // R3
  div_pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(samp_rise && samp_fall));
endmodule

// File: rtl/cfm_rearm.sv
module cfm_rearm #(
  parameter int unsigned CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic prim_fall,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (busy && prim_fall) begin
        if (cnt_q == CW'(CYCLES - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R8
  rearm_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(CYCLES));

  // R8
  rearm_done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/clk_fail_monitor.sv
module clk_fail_monitor
  import cfm_pkg::*;
#(
  parameter int unsigned REF_DIV    = 64,
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned SYNC_STAGES = CFM_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic prim_clk,
  input  logic ref_clk,
  input  logic ost_done,
  input  logic mon_en,
  input  logic osc_crystal,
  input  logic src_toggle,
  input  logic flag_clr,
  input  logic irq_en,
  output logic fail_flag,
  output logic fail_irq,
  output logic force_internal
);
  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw_in, synced;
  logic s_prim, s_ref, s_ost;
  logic prim_d, ref_d;
  logic prim_fall, ref_rise;
  logic samp_rise, samp_fall;
  logic rearm_busy, rearm_done, rearm_start;
  logic seen_q, fail_q, flag_q, irq_q;
  logic armed, fail_det, block_rst;
  osc_kind_e kind;

  assign raw_in = {ost_done, ref_clk, prim_clk};
  assign kind   = osc_kind_e'(osc_crystal);

  cfm_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_in(raw_in), .d_out(synced)
  );

  assign {s_ost, s_ref, s_prim} = synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_d <= 1'b0;
      ref_d  <= 1'b0;
    end else begin
      prim_d <= s_prim;
      ref_d  <= s_ref;
    end
  end

  assign prim_fall = prim_d & ~s_prim;
  assign ref_rise  = ~ref_d & s_ref;

  cfm_divider #(.DIV(REF_DIV)) u_div (
    .clk(clk), .rst(rst), .ref_rise(ref_rise),
    .samp_rise(samp_rise), .samp_fall(samp_fall)
  );

  assign block_rst   = rst | ~mon_en;
  assign rearm_start = fail_q & src_toggle & (kind == OSC_CRYSTAL);

  cfm_rearm #(.CYCLES(OST_CYCLES)) u_rearm (
    .clk(clk), .rst(block_rst), .start(rearm_start),
    .prim_fall(prim_fall), .busy(rearm_busy), .done(rearm_done)
  );

  assign armed = mon_en & ~rearm_busy & ~fail_q &
                 ((kind == OSC_EXT_OR_RC) | s_ost);

  // Detector latch: preset while not armed so a fresh window never trips.
  always_ff @(posedge clk) begin
    if (rst || !armed)   seen_q <= 1'b1;
    else if (prim_fall)  seen_q <= 1'b1;
    else if (samp_rise)  seen_q <= 1'b0;
  end

  assign fail_det = armed & samp_fall & ~seen_q;

  always_ff @(posedge clk) begin
    if (block_rst) begin
      fail_q <= 1'b0;
    end else if (fail_det) begin
      fail_q <= 1'b1;
    end else if (fail_q && rearm_done) begin
      fail_q <= 1'b0;
    end else if (fail_q && src_toggle && kind == OSC_EXT_OR_RC) begin
      fail_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (block_rst)     flag_q <= 1'b0;
    else if (fail_det) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (block_rst) irq_q <= 1'b0;
    else           irq_q <= flag_q & irq_en;
  end

  assign fail_flag      = flag_q;
  assign fail_irq       = irq_q;
  assign force_internal = fail_q;

  // R3
  fail_at_sample_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_q) |-> $past(samp_fall));

  // R5
  no_auto_return_chk: assert property (@(posedge clk) disable iff (rst)
    fail_q && mon_en && !rearm_done && !src_toggle |=> fail_q);

  // R9
  armed_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_q) |-> $past(!osc_crystal || s_ost));

  // R4
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    fail_irq |-> (fail_flag || $past(flag_clr) || $past(!mon_en)));

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mon_en |=> (!fail_flag && !force_internal));
endmodule

// File: tb/clk_fail_monitor_tb_top.sv
module clk_fail_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRIM_HALF  = 20;
  localparam int REF_HALF   = 30;
  localparam int WATCHDOG   = 400000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prim_clk = 1'b0, ref_clk = 1'b0;
  logic ost_done = 1'b0, mon_en = 1'b0, osc_crystal = 1'b0;
  logic src_toggle = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
  logic fail_flag, fail_irq, force_internal;
  logic prim_run = 1'b1;
  int n_checks = 0, n_fails = 0;

  clk_fail_monitor #(.REF_DIV(8), .OST_CYCLES(16)) dut_i (
    .clk(clk), .rst(rst), .prim_clk(prim_clk), .ref_clk(ref_clk),
    .ost_done(ost_done), .mon_en(mon_en), .osc_crystal(osc_crystal),
    .src_toggle(src_toggle), .flag_clr(flag_clr), .irq_en(irq_en),
    .fail_flag(fail_flag), .fail_irq(fail_irq), .force_internal(force_internal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  initial begin #3; forever #(REF_HALF) ref_clk = ~ref_clk; end
  initial begin
    #7;
    forever begin
      #(PRIM_HALF);
      if (prim_run) prim_clk = ~prim_clk;
      else          prim_clk = 1'b1;
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic crystal, input logic ost);
    @(negedge clk);
    rst = 1'b1; prim_run = 1'b1; osc_crystal = crystal; ost_done = ost;
    mon_en = 1'b1; irq_en = 1'b0; src_toggle = 1'b0; flag_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 1'b0);
    check(fail_flag, 1'b0, "R10 reset flag");
    check(force_internal, 1'b0, "R10 reset select");
    check(fail_irq, 1'b0, "R4 reset irq");
  endtask

  task automatic t_running_and_stop();
    do_reset(1'b0, 1'b0);
    #5000;
    check(fail_flag, 1'b0, "R1 running flag");
    check(force_internal, 1'b0, "R1 running select");
    prim_run = 1'b0;
    #120;
    check(fail_flag, 1'b0, "R3 no early fail");
    #1500;
    check(fail_flag, 1'b1, "R2 stop flag");
    check(force_internal, 1'b1, "R2 stop select");
    check(fail_irq, 1'b0, "R4 irq masked");
    @(negedge clk); irq_en = 1'b1;
    #50;
    check(fail_irq, 1'b1, "R4 irq enabled");
    @(negedge clk); irq_en = 1'b0;
    #50;
    check(fail_irq, 1'b0, "R4 irq disabled");
    check(fail_flag, 1'b1, "R4 flag kept");
    prim_run = 1'b1;
    #3000;
    check(force_internal, 1'b1, "R5 no auto return");
    pulse(flag_clr);
    #30;
    check(fail_flag, 1'b0, "R6 flag cleared");
    check(force_internal, 1'b1, "R6 select kept");
    pulse(src_toggle);
    #50;
    check(force_internal, 1'b0, "R7 ext toggle release");
    #3000;
    check(fail_flag, 1'b0, "R7 stays healthy");
  endtask

  task automatic t_toggle_ignored();
    do_reset(1'b0, 1'b0);
    #1000;
    pulse(src_toggle);
    #1000;
    check(force_internal, 1'b0, "R11 toggle ignored select");
    check(fail_flag, 1'b0, "R11 toggle ignored flag");
  endtask

  task automatic t_crystal_rearm();
    do_reset(1'b1, 1'b1);
    #1000;
    prim_run = 1'b0;
    #1600;
    check(force_internal, 1'b1, "R2 crystal stop select");
    prim_run = 1'b1;
    #200;
    pulse(src_toggle);
    #300;
    check(force_internal, 1'b1, "R8 held during rearm");
    #1200;
    check(force_internal, 1'b0, "R8 released after count");
    #2000;
    check(fail_flag, 1'b1, "R8 flag sticky after rearm");
    check(force_internal, 1'b0, "R8 monitoring healthy again");
  endtask

  task automatic t_wait_start();
    do_reset(1'b1, 1'b0);
    prim_run = 1'b0;
    #2000;
    check(fail_flag, 1'b0, "R9 no fail before start done");
    @(negedge clk); ost_done = 1'b1;
    #1600;
    check(fail_flag, 1'b1, "R9 fail after start done");
  endtask

  task automatic t_disable();
    do_reset(1'b0, 1'b0);
    prim_run = 1'b0;
    #1600;
    check(force_internal, 1'b1, "R10 failed before disable");
    @(negedge clk); mon_en = 1'b0;
    #50;
    check(force_internal, 1'b0, "R10 disable select");
    check(fail_flag, 1'b0, "R10 disable flag");
    #2000;
    check(fail_flag, 1'b0, "R10 disabled stays quiet");
  endtask

  initial begin
    #(WATCHDOG);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_running_and_stop();
    t_toggle_ignored();
    t_crystal_rearm();
    t_wait_start();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule